// File: doc/BRIEF.md
# Autonegotiation Link Resolver

This block turns snapshots of a copper PHY's management registers into a link verdict: whether the link is up, at which speed, and in which duplex. A sequencer outside the block fetches the registers. It presents the basic status word, the gigabit control and status words, the local advertisement word, the partner ability word, a MAC-side link bit and an interface-mode flag, and then pulses `start`.

On `start`, the block resolves speed and duplex from the presented words. It remembers the status word it used and raises `resample_req` to ask for a fresh copy of the status word. The sequencer answers with `stat_ack` and the fresh status on `mii_stat`. If the fresh word equals the remembered one, the pending verdict is latched onto the outputs and `res_valid` pulses. If it differs, the block resolves again with the fresh word and asks again. This repeats until two consecutive status reads agree.

Top module: `an_link_resolver`

## Requirements
- R1: When `mode_mii` is 0 and both `gig_ctl[9]` (local 1000 full-duplex advertised) and `gig_stat[11]` (partner 1000 full-duplex capable) are 1, the resolution is speed code 3 (1000) with duplex code 2 (full).
- R2: Otherwise the common set is `an_adv & an_lpa`. When `an_lpa` is zero, the common set is `an_adv` alone.
- R3: The block picks from the common set in this priority order: bit 8 (100 full, speed 2, duplex 2), bit 7 (100 half, speed 2, duplex 1), bit 6 (10 full, speed 1, duplex 2), bit 5 (10 half, speed 1, duplex 1). With none of these bits set, the result is speed 0 (none) and duplex 0 (unknown).
- R4: When `mode_mii` is 1, the gigabit words are ignored and only the R2/R3 resolution applies.
- R5: `link_up` is 1 only when the resolved speed is not 0, the duplex is not 0, `mii_stat[2]` (PHY link) is 1 and `mac_link` is 1.
- R6: While `link_up` is 0, `speed` reads 0 and `duplex` reads 0.
- R7: After an accepted `start`, `resample_req` stays high until a `stat_ack`. An ack whose `mii_stat` differs from the status word last used keeps `resample_req` high, leaves `res_valid` low and leaves the outputs unchanged. The block then resolves again with the presented words.
- R8: An ack whose `mii_stat` equals the status word last used latches the pending verdict in that edge and pulses `res_valid` for exactly one cycle. At all other times the outputs hold.
- R9: After reset, `link_up`, `speed`, `duplex`, `res_valid` and `resample_req` are 0. A `start` while `resample_req` is high is ignored, and so is a `stat_ack` while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a resolution with the presented words |
| mode_mii | input | 1 | 1 = MII interface (no gigabit), 0 = RGMII |
| mii_stat | input | 16 | PHY basic status word |
| gig_ctl | input | 16 | PHY 1000BASE-T control word |
| gig_stat | input | 16 | PHY 1000BASE-T status word |
| an_adv | input | 16 | Local advertisement word |
| an_lpa | input | 16 | Link partner ability word |
| mac_link | input | 1 | MAC-side link indication |
| resample_req | output | 1 | Asks for a fresh status word |
| stat_ack | input | 1 | Fresh status word present on `mii_stat` |
| link_up | output | 1 | Resolved link state |
| speed | output | 2 | 0 none, 1 = 10, 2 = 100, 3 = 1000 |
| duplex | output | 2 | 0 unknown, 1 half, 2 full |
| res_valid | output | 1 | One-cycle strobe on a stable verdict |

## Verification
Random advertisement and partner words, with bits biased toward sparse masks, exercise the priority pick. The priority cases that matter are those where several abilities overlap and those where the partner word is zero, since a zero partner word must fall back to the local word instead of yielding no speed. The gigabit bits are toggled in both interface modes: a gigabit verdict in MII mode shows that the mode gate is wrong. The PHY and MAC link bits are varied separately, which shows the agreement rule and the forced zero codes on a down link. A directed run answers the first resample with a changed status word. It shows that the block repeats resolution and that the verdict follows the final, stable status.

// File: rtl/an_link_resolver.sv
module an_link_resolver (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode_mii,
  input  logic [15:0] mii_stat,
  input  logic [15:0] gig_ctl,
  input  logic [15:0] gig_stat,
  input  logic [15:0] an_adv,
  input  logic [15:0] an_lpa,
  input  logic        mac_link,
  output logic        resample_req,
  input  logic        stat_ack,
  output logic        link_up,
  output logic [1:0]  speed,
  output logic [1:0]  duplex,
  output logic        res_valid
);
  logic [15:0] common;
  logic        gig;
  logic [1:0]  r_spd, r_dup;
  logic        r_link;
  logic [15:0] snap;
  logic        p_link;
  logic [1:0]  p_spd, p_dup;

  assign gig    = !mode_mii && gig_ctl[9] && gig_stat[11];
  assign common = (an_lpa == 16'h0) ? an_adv : (an_adv & an_lpa);

  always_comb begin
    r_spd = 2'd0;
    r_dup = 2'd0;
    if (gig) begin
      r_spd = 2'd3; r_dup = 2'd2;
    end else if (common[8]) begin
      r_spd = 2'd2; r_dup = 2'd2;
    end else if (common[7]) begin
      r_spd = 2'd2; r_dup = 2'd1;
    end else if (common[6]) begin
      r_spd = 2'd1; r_dup = 2'd2;
    end else if (common[5]) begin
      r_spd = 2'd1; r_dup = 2'd1;
    end
  end

  assign r_link = (r_spd != 2'd0) && (r_dup != 2'd0) && mii_stat[2] && mac_link;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resample_req <= 1'b0;
      res_valid    <= 1'b0;
      link_up      <= 1'b0;
      speed        <= 2'd0;
      duplex       <= 2'd0;
      snap         <= 16'h0;
      p_link       <= 1'b0;
      p_spd        <= 2'd0;
      p_dup        <= 2'd0;
    end else begin
      res_valid <= 1'b0;
      if (!resample_req) begin
        if (start) begin
          snap         <= mii_stat;
          p_link       <= r_link;
          p_spd        <= r_link ? r_spd : 2'd0;
          p_dup        <= r_link ? r_dup : 2'd0;
          resample_req <= 1'b1;
        end
      end else if (stat_ack) begin
        if (mii_stat == snap) begin
          link_up      <= p_link;
          speed        <= p_spd;
          duplex       <= p_dup;
          res_valid    <= 1'b1;
          resample_req <= 1'b0;
        end else begin
          snap   <= mii_stat;
          p_link <= r_link;
          p_spd  <= r_link ? r_spd : 2'd0;
          p_dup  <= r_link ? r_dup : 2'd0;
        end
      end
    end
  end
endmodule

module an_link_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       resample_req,
  input logic       stat_ack,
  input logic       link_up,
  input logic [1:0] speed,
  input logic [1:0] duplex,
  input logic       res_valid
);
  // R5
  up_codes_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (speed != 2'd0 && duplex != 2'd0));
  // R6
  down_codes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> (speed == 2'd0 && duplex == 2'd0));
  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resample_req && !stat_ack) |=> resample_req);
  // R8
  valid_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(stat_ack) && $past(resample_req)));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({link_up, speed, duplex}));
  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind an_link_resolver an_link_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resample_req(resample_req), .stat_ack(stat_ack),
  .link_up(link_up), .speed(speed), .duplex(duplex), .res_valid(res_valid)
);

// File: tb/an_link_resolver_test.sv
module an_link_resolver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_mii = 1'b0, mac_link = 1'b0, stat_ack = 1'b0;
  logic [15:0] mii_stat = 16'h0, gig_ctl = 16'h0, gig_stat = 16'h0, an_adv = 16'h0, an_lpa = 16'h0;
  logic resample_req, link_up, res_valid;
  logic [1:0] speed, duplex;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  an_link_resolver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_mii(mode_mii),
    .mii_stat(mii_stat), .gig_ctl(gig_ctl), .gig_stat(gig_stat),
    .an_adv(an_adv), .an_lpa(an_lpa), .mac_link(mac_link),
    .resample_req(resample_req), .stat_ack(stat_ack), .link_up(link_up),
    .speed(speed), .duplex(duplex), .res_valid(res_valid)
  );

  function automatic logic [4:0] model(input logic mm, input logic [15:0] st, input logic [15:0] gc,
                                       input logic [15:0] gs, input logic [15:0] ad, input logic [15:0] lp,
                                       input logic ml);
    logic [15:0] c;
    logic [1:0] s, d;
    logic up;
    c = (lp == 0) ? ad : (ad & lp);
    s = 0; d = 0;
    if (!mm && gc[9] && gs[11]) begin s = 3; d = 2; end
    else if (c[8]) begin s = 2; d = 2; end
    else if (c[7]) begin s = 2; d = 1; end
    else if (c[6]) begin s = 1; d = 2; end
    else if (c[5]) begin s = 1; d = 1; end
    up = (s != 0) && st[2] && ml;
    if (!up) begin s = 0; d = 0; end
    return {up, s, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic resolve_once(input string req);
    logic [4:0] e;
    e = model(mode_mii, mii_stat, gig_ctl, gig_stat, an_adv, an_lpa, mac_link);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({req, " R7 req"}, resample_req, 1);
    stat_ack = 1'b1;
    @(negedge clk) stat_ack = 1'b0;
    chk({req, " R8 valid"}, res_valid, 1);
    chk(req, {link_up, speed, duplex}, e);
    @(negedge clk);
    chk({req, " R8 pulse"}, res_valid, 0);
  endtask

  function automatic logic [15:0] sparse();
    return 16'($urandom) & 16'($urandom) & 16'h01e0 | (16'($urandom) & 16'hfe1f);
  endfunction

  initial begin
    logic [4:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9
    chk("R9 reset", {resample_req, res_valid, link_up, speed, duplex}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    stat_ack = 1'b1;
    @(negedge clk) stat_ack = 1'b0;
    chk("R9 stray ack", {resample_req, res_valid}, 0);

    mac_link = 1; mii_stat = 16'h0004;
    // R1
    mode_mii = 0; gig_ctl = 16'h0200; gig_stat = 16'h0800; an_adv = 16'h01e1; an_lpa = 16'h01e1;
    resolve_once("R1 gig");
    chk("R1 speed", speed, 3);
    // R4
    mode_mii = 1;
    resolve_once("R4 mii");
    chk("R4 speed", speed, 2);
    // R2
    mode_mii = 0; gig_ctl = 0; an_adv = 16'h0061; an_lpa = 16'h0000;
    resolve_once("R2 zero lpa");
    chk("R2 fallback", {speed, duplex}, {2'd1, 2'd2});
    // R3
    an_adv = 16'h01e1; an_lpa = 16'h00a1;
    resolve_once("R3 priority");
    chk("R3 100half", {speed, duplex}, {2'd2, 2'd1});
    an_adv = 16'h0101; an_lpa = 16'h0041;
    resolve_once("R3 no common");
    chk("R3 none", {link_up, speed, duplex}, 0);
    // R5 R6
    an_adv = 16'h01e1; an_lpa = 16'h01e1; mac_link = 0;
    resolve_once("R5 mac down");
    chk("R6 down", {link_up, speed, duplex}, 0);
    mac_link = 1; mii_stat = 16'h0000;
    resolve_once("R5 phy down");

    // R7 mismatch then stable
    mii_stat = 16'h0000; an_adv = 16'h0141; an_lpa = 16'h0000;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    mii_stat = 16'h002c; stat_ack = 1'b1;
    @(negedge clk) stat_ack = 1'b0;
    chk("R7 still req", resample_req, 1);
    chk("R7 no valid", res_valid, 0);
    chk("R7 outputs held", {link_up, speed, duplex}, 0);
    start = 1'b1;
    mii_stat = 16'h0000;
    @(negedge clk) start = 1'b0;
    chk("R9 start ignored", resample_req, 1);
    mii_stat = 16'h002c;
    @(negedge clk) stat_ack = 1'b1;
    @(negedge clk) stat_ack = 1'b0;
    chk("R8 stable valid", res_valid, 1);
    chk("R7 final verdict", {link_up, speed, duplex}, {1'b1, 2'd2, 2'd2});

    // random
    for (int i = 0; i < 300; i++) begin
      mode_mii = 1'($urandom);
      mac_link = ($urandom % 4) != 0;
      mii_stat = 16'($urandom) | (($urandom % 4 != 0) ? 16'h0004 : 16'h0);
      if ($urandom % 5 == 0) mii_stat[2] = 0;
      gig_ctl = 16'($urandom);
      gig_stat = 16'($urandom);
      an_adv = sparse();
      an_lpa = ($urandom % 4 == 0) ? 16'h0 : sparse();
      resolve_once("R3 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R7 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule